// File: doc/BRIEF.md
# Programmable Eight-Input Expandable Gate

This block is a purely combinational gate. It takes eight data bits split into two groups of four, a three-bit function code, an output-enable bit and one expansion bit. The code picks one of eight gate functions. Four of them act on all eight bits at once: OR, NOR, AND and NAND. The other four first reduce each group and then combine the two results: OR/AND, OR/NAND, AND/OR and AND/NOR. The result leaves the block as a data bit together with an enable flag, so a bus or the chip top can infer a tri-state driver from the pair. The data bit keeps showing the selected function even while the enable is low.

The expansion bit brings in a term computed outside the block, which widens the gate. Each function family merges that term with its own polarity, so an expansion bit tied low never changes the result. The top module is a two-stage cascade. A lower cell with its own expansion input feeds its data bit straight into the expansion input of an upper cell. Both cells are exposed, which allows one 8-input gate to be swept on its own, and it also allows 12- or 16-input gates to be built.

This block holds no state and has no clock, so it has no state machine. The function code plays the role a state would, and each code is named in the requirements below.

Top module: `xgate_pair`

## Requirements
- R1: Code 000 (bit 2, bit 1, bit 0 of the select port) gives NOR: out = ~(any data bit | expand).
- R2: Code 001 gives OR: out = any data bit | expand.
- R3: Code 100 gives AND: out = all data bits & ~expand.
- R4: Code 101 gives NAND: out = ~(all data bits & ~expand).
- R5: Code 010 gives OR/AND: out = (|data[3:0]) & (|data[7:4]) & ~expand.
- R6: Code 011 gives OR/NAND, the inverse of the R5 value.
- R7: Code 110 gives AND/NOR: out = ~((&data[3:0]) | (&data[7:4]) | expand).
- R8: Code 111 gives AND/OR, the inverse of the R7 value.
- R9: Each cell's output enable equals its drive-enable input. The data bit still carries the function value when the enable is low.
- R10: With expand low, every code returns the plain eight-input function of the data alone.
- R11: The upper cell's expand input is the lower cell's data bit. With the lower cell at code 001 and the upper cell at code 000, the upper output is the NOR of all 16 data bits.
- R12: With the lower cell at code 000, its upper group tied low and the upper cell at code 010, the upper output is (|hi[3:0]) & (|hi[7:4]) & (|lo[3:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_data | input | 8 | Data bits of the lower cell; group 0 is [3:0] |
| lo_sel | input | 3 | Function code of the lower cell |
| lo_expand | input | 1 | External expansion term of the lower cell |
| lo_drive_en | input | 1 | Output enable of the lower cell |
| hi_data | input | 8 | Data bits of the upper cell |
| hi_sel | input | 3 | Function code of the upper cell |
| hi_drive_en | input | 1 | Output enable of the upper cell |
| lo_out | output | 1 | Lower cell data bit, also the upper cell's expansion term |
| lo_out_en | output | 1 | Lower cell output enable |
| hi_out | output | 1 | Upper cell data bit |
| hi_out_en | output | 1 | Upper cell output enable |

## Verification
In the same evaluation, the expansion merge and the group reduction both contribute to the result. So does the cascade, where the lower cell's value is the upper cell's expansion term. The bench sweeps every data pattern against both expansion values for every code on the lower cell. In each step it also sets random codes and data on the upper cell. The upper output is then judged against a reference model that nests the lower reference into the upper one. This shows that the expansion polarity is correct across the stage boundary, and not just within one cell.

// File: rtl/xgate_pkg.sv
package xgate_pkg;

    // Function codes; bit 2 selects the AND family, bit 1 the two-level form.
    typedef enum logic [2:0] {
        FN_NOR    = 3'b000,
        FN_OR     = 3'b001,
        FN_ORAND  = 3'b010,
        FN_ORNAND = 3'b011,
        FN_AND    = 3'b100,
        FN_NAND   = 3'b101,
        FN_ANDNOR = 3'b110,
        FN_ANDOR  = 3'b111
    } gfunc_e;

    localparam int unsigned NUM_GROUPS = 2;

endpackage

// File: rtl/xgate_group.sv
module xgate_group #(
    parameter int unsigned WIDTH_PER_GROUP = 4
) (
    input  logic [WIDTH_PER_GROUP-1:0] grp_bits,
    output logic                       any_set,
    output logic                       all_set
);
    localparam int unsigned CHAIN = WIDTH_PER_GROUP + 1;

    logic [CHAIN-1:0] or_chain;
    logic [CHAIN-1:0] and_chain;

    assign or_chain[0]  = 1'b0;
    assign and_chain[0] = 1'b1;

    for (genvar gi = 0; gi < WIDTH_PER_GROUP; gi++) begin : g_reduce
        assign or_chain[gi+1]  = or_chain[gi]  | grp_bits[gi];
        assign and_chain[gi+1] = and_chain[gi] & grp_bits[gi];
    end

    assign any_set = or_chain[CHAIN-1];
    assign all_set = and_chain[CHAIN-1];

endmodule

// File: rtl/xgate_merge.sv
module xgate_merge
    import xgate_pkg::*;
(
    input  logic [NUM_GROUPS-1:0] grp_any,
    input  logic [NUM_GROUPS-1:0] grp_all,
    input  logic [2:0]            sel,
    input  logic                  expand,
    output logic                  result
);
    gfunc_e fn;
    logic   sum_one;   // single-level OR path
    logic   prod_one;  // single-level AND path
    logic   prod_two;  // OR/AND path
    logic   sum_two;   // AND/OR path

    assign fn = gfunc_e'(sel);

    always_comb begin
        sum_one  = (|grp_any) | expand;
        prod_one = (&grp_all) & ~expand;
        prod_two = (&grp_any) & ~expand;
        sum_two  = (|grp_all) | expand;
        unique case (fn)
            FN_NOR:    result = ~sum_one;
            FN_OR:     result =  sum_one;
            FN_ORAND:  result =  prod_two;
            FN_ORNAND: result = ~prod_two;
            FN_AND:    result =  prod_one;
            FN_NAND:   result = ~prod_one;
            FN_ANDNOR: result = ~sum_two;
            FN_ANDOR:  result =  sum_two;
            default:   result = 1'b0;
        endcase
    end

    always_comb begin
        p_or_expand_r2: assert (!(fn == FN_OR && expand) || result)
            else $error("OR with expand high must be 1");
        p_nor_expand_r1: assert (!(fn == FN_NOR && expand) || !result)
            else $error("NOR with expand high must be 0");
        p_and_expand_r3: assert (!(fn == FN_AND && expand) || !result)
            else $error("AND with expand high must be 0");
        p_orand_empty_r5: assert (!(fn == FN_ORAND && !grp_any[0]) || !result)
            else $error("OR/AND with empty group 0 must be 0");
        p_andor_full_r8: assert (!(fn == FN_ANDOR && grp_all[1]) || result)
            else $error("AND/OR with full group 1 must be 1");
    end

endmodule

// File: rtl/xgate_cell.sv
module xgate_cell
    import xgate_pkg::*;
#(
    parameter int unsigned WIDTH_PER_GROUP = 4
) (
    input  logic [NUM_GROUPS*WIDTH_PER_GROUP-1:0] data_in,
    input  logic [2:0]                            sel,
    input  logic                                  expand,
    input  logic                                  drive_en,
    output logic                                  out_bit,
    output logic                                  out_en
);
    logic [NUM_GROUPS-1:0] grp_any;
    logic [NUM_GROUPS-1:0] grp_all;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        xgate_group #(.WIDTH_PER_GROUP(WIDTH_PER_GROUP)) u_grp (
            .grp_bits (data_in[g*WIDTH_PER_GROUP +: WIDTH_PER_GROUP]),
            .any_set  (grp_any[g]),
            .all_set  (grp_all[g])
        );
    end

    xgate_merge u_merge (
        .grp_any (grp_any),
        .grp_all (grp_all),
        .sel     (sel),
        .expand  (expand),
        .result  (out_bit)
    );

    assign out_en = drive_en;

endmodule

// File: rtl/xgate_pair.sv
module xgate_pair
    import xgate_pkg::*;
#(
    parameter int unsigned WIDTH_PER_GROUP = 4,
    localparam int unsigned DW = NUM_GROUPS * WIDTH_PER_GROUP
) (
    input  logic [DW-1:0] lo_data,
    input  logic [2:0]    lo_sel,
    input  logic          lo_expand,
    input  logic          lo_drive_en,
    input  logic [DW-1:0] hi_data,
    input  logic [2:0]    hi_sel,
    input  logic          hi_drive_en,
    output logic          lo_out,
    output logic          lo_out_en,
    output logic          hi_out,
    output logic          hi_out_en
);
    xgate_cell #(.WIDTH_PER_GROUP(WIDTH_PER_GROUP)) u_lo (
        .data_in  (lo_data),
        .sel      (lo_sel),
        .expand   (lo_expand),
        .drive_en (lo_drive_en),
        .out_bit  (lo_out),
        .out_en   (lo_out_en)
    );

    // The lower cell's data bit is the upper cell's expansion term.
    xgate_cell #(.WIDTH_PER_GROUP(WIDTH_PER_GROUP)) u_hi (
        .data_in  (hi_data),
        .sel      (hi_sel),
        .expand   (lo_out),
        .drive_en (hi_drive_en),
        .out_bit  (hi_out),
        .out_en   (hi_out_en)
    );

    always_comb begin
        p_cascade_nor_r11: assert (!(lo_sel == FN_OR && hi_sel == FN_NOR && (|lo_data)) || !hi_out)
            else $error("16-input NOR must be 0 when any lower bit is set");
    end

endmodule

// File: tb/xgate_pair_bench.sv
module xgate_pair_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [7:0] lo_data, hi_data;
    logic [2:0] lo_sel, hi_sel;
    logic lo_expand, lo_drive_en, hi_drive_en;
    logic lo_out, lo_out_en, hi_out, hi_out_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    xgate_pair u_xgate_pair (
        .lo_data(lo_data), .lo_sel(lo_sel), .lo_expand(lo_expand),
        .lo_drive_en(lo_drive_en), .hi_data(hi_data), .hi_sel(hi_sel),
        .hi_drive_en(hi_drive_en), .lo_out(lo_out), .lo_out_en(lo_out_en),
        .hi_out(hi_out), .hi_out_en(hi_out_en)
    );

    function automatic logic ref_gate(logic [2:0] s, logic [7:0] d, logic x);
        logic oa, ob, aa, ab;
        oa = |d[3:0]; ob = |d[7:4]; aa = &d[3:0]; ab = &d[7:4];
        case (s)
            3'b000: return ~(oa | ob | x);
            3'b001: return oa | ob | x;
            3'b010: return oa & ob & ~x;
            3'b011: return ~(oa & ob & ~x);
            3'b100: return aa & ab & ~x;
            3'b101: return ~(aa & ab & ~x);
            3'b110: return ~(aa | ab | x);
            default: return aa | ab | x;
        endcase
    endfunction

    function automatic logic plain_gate(logic [2:0] s, logic [7:0] d);
        case (s)
            3'b000: return ~(|d);
            3'b001: return |d;
            3'b010: return (|d[3:0]) & (|d[7:4]);
            3'b011: return ~((|d[3:0]) & (|d[7:4]));
            3'b100: return &d;
            3'b101: return ~(&d);
            3'b110: return ~((&d[3:0]) | (&d[7:4]));
            default: return (&d[3:0]) | (&d[7:4]);
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b100: return "R3";
            3'b101: return "R4";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b110: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(logic act, logic exp, string req, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] ld, logic [2:0] ls, logic lx, logic le,
                         logic [7:0] hd, logic [2:0] hs, logic he);
        @(posedge clk);
        lo_data = ld; lo_sel = ls; lo_expand = lx; lo_drive_en = le;
        hi_data = hd; hi_sel = hs; hi_drive_en = he;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        lo_data = '0; hi_data = '0; lo_sel = '0; hi_sel = '0;
        lo_expand = 1'b0; lo_drive_en = 1'b0; hi_drive_en = 1'b0;

        // Quiet state: all zero inputs, both cells NOR.
        drive(8'h00, 3'b000, 1'b0, 1'b0, 8'h00, 3'b000, 1'b0);
        chk(lo_out, 1'b1, "R1", "idle lower NOR of zeros");
        chk(hi_out, 1'b0, "R11", "idle upper NOR with expand=1");
        chk(lo_out_en, 1'b0, "R9", "idle enable low");

        // Exhaustive lower-cell sweep with random upper stage.
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 2; x++) begin
                for (int d = 0; d < 256; d++) begin
                    logic [7:0] hd; logic [2:0] hs; logic le, he, lexp;
                    hd = 8'($urandom); hs = 3'($urandom);
                    le = 1'($urandom); he = 1'($urandom);
                    drive(8'(d), 3'(s), 1'(x), le, hd, hs, he);
                    lexp = ref_gate(3'(s), 8'(d), 1'(x));
                    chk(lo_out, lexp, tag_of(3'(s)), "lower function");
                    if (x == 0)
                        chk(lo_out, plain_gate(3'(s), 8'(d)), "R10", "expand low is neutral");
                    chk(lo_out_en, le, "R9", "lower enable");
                    chk(hi_out_en, he, "R9", "upper enable");
                    chk(hi_out, ref_gate(hs, hd, lexp), "R11", "upper uses lower as expand");
                end
            end
        end

        // Data bit valid while disabled.
        drive(8'hFF, 3'b100, 1'b0, 1'b0, 8'h0F, 3'b111, 1'b0);
        chk(lo_out, 1'b1, "R9", "AND value visible while disabled");
        chk(hi_out, 1'b1, "R9", "AND/OR value visible while disabled");

        // 16-input NOR: all zero, then walking one.
        drive(8'h00, 3'b001, 1'b0, 1'b1, 8'h00, 3'b000, 1'b1);
        chk(hi_out, 1'b1, "R11", "16-input NOR of zeros");
        for (int b = 0; b < 16; b++) begin
            logic [15:0] w;
            w = 16'(1) << b;
            drive(w[7:0], 3'b001, 1'b0, 1'b1, w[15:8], 3'b000, 1'b1);
            chk(hi_out, 1'b0, "R11", "16-input NOR walking one");
        end

        // 12-input OR/AND built from a 4-input NOR expander.
        for (int k = 0; k < 300; k++) begin
            logic [3:0] xl; logic [7:0] hd; logic e;
            xl = 4'($urandom); hd = 8'($urandom);
            if (k < 16) begin xl = 4'(k); hd = 8'h11; end
            drive({4'h0, xl}, 3'b000, 1'b0, 1'b1, hd, 3'b010, 1'b1);
            e = (|hd[3:0]) & (|hd[7:4]) & (|xl);
            chk(hi_out, e, "R12", "12-input OR/AND");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule